// File: doc/BRIEF.md
# Cascadable Display Column Data Capture

This block is the digital front end of a display source driver with 240 column outputs. Each rising edge of the shift clock can take one 18-bit pixel word. A word holds three 6-bit gray codes, and each code has bit 0 as its least significant bit. A pointer steers every word into the next three column slots of a data register, so a full row takes 80 clocks. The fill starts when the active start input is seen high, and it runs upward or downward across the columns depending on a direction input. On the edge that stores the last word, the block raises a start pulse on the pin at the far side, so a neighbouring driver can continue the row.

A strobe copies the whole data register into an output latch. That latch would feed the per-column converters. The rising edge of the strobe also does four other things: it stops and clears the fill pointer, it captures a polarity input, it updates a common-electrode polarity output, and it turns the column output enable off until the strobe falls. Two options apply to the data. An invert input complements words as they are captured. An 8-color mode latches every code as all-zeros or all-ones, taken from its MSB.

Top module: `lcd_col_capture`

## Requirements
- R1: After a synchronous reset, the following outputs are all 0: `row_codes`, `pol_out`, `com_out`, `out_en`, `row_valid`, `start_l_out` and `start_r_out`.
- R2: With `dir_right`=1, the start is taken from `start_r_in`. Word k (k=0 is the word present on the edge where the start is seen high) writes code j (bits 6j+5:6j) into column 3k+j, counting columns from 0.
- R3: With `dir_right`=0, the start is taken from `start_l_in`. Word k writes code j into column 239-(3k+j).
- R4: The edge that stores word 79 sets the output on the far side for exactly one cycle: `start_l_out` when filling right, `start_r_out` when filling left. The other start output stays 0.
- R5: `row_codes` changes only on an edge where `strobe` is high. On that edge it takes the data register contents. Column c occupies bits 6c+5:6c.
- R6: A strobe rising edge clears the fill pointer. Words that follow without a new start are not stored.
- R7: When `inv_en` is 1 on a capture edge, that word is stored bit-inverted.
- R8: `pol_out` takes `pol_in` on the strobe rising edge and holds its value at all other times.
- R9: `com_out` is registered. It equals NOT of the polarity that is held, one cycle after `com_sel`=1, and it is 0 one cycle after `com_sel`=0.
- R10: `out_en` goes to 0 on the strobe rising edge and stays 0 while `strobe` is high. It goes to 1 on the first edge with `strobe` low, and only once `row_valid` is 1. `row_valid` is set by the first strobe after reset.
- R11: With `mode8`=1 on a latch edge, each latched code becomes 63 if its bit 5 is 1 and 0 otherwise.
- R12: A start input that is seen high while a row is being filled is ignored. The fill continues in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_right | input | 1 | 1: fill upward from column 0; 0: fill downward from column 239 |
| start_l_in | input | 1 | Start input used when filling leftward |
| start_r_in | input | 1 | Start input used when filling rightward |
| start_l_out | output | 1 | Cascade start output when filling rightward |
| start_r_out | output | 1 | Cascade start output when filling leftward |
| pix_in | input | 18 | Three 6-bit gray codes |
| inv_en | input | 1 | Invert incoming words |
| strobe | input | 1 | Latch, pointer clear and polarity capture |
| pol_in | input | 1 | Polarity input |
| com_sel | input | 1 | 1: drive com_out from polarity; 0: hold it low |
| mode8 | input | 1 | 8-color MSB expansion at latch |
| row_codes | output | 1440 | Latched codes, column c at bits 6c+5:6c |
| pol_out | output | 1 | Captured polarity |
| com_out | output | 1 | Common-electrode polarity output |
| out_en | output | 1 | Column output enable |
| row_valid | output | 1 | Set once a strobe has been seen |

## Verification
A pointer that is off by one or runs in the wrong direction shows as shifted or mirrored codes in `row_codes`. These appear on the edge right after the next strobe, and the cascade pulse also lands in the wrong cycle within the same 80-clock row. A pointer that is left busy after a strobe lets discarded words overwrite columns, which shows at the following strobe. A stale polarity or enable register shows on `pol_out`, `com_out` or `out_en` within one clock of the strobe edge or of the `com_sel` change.

// File: rtl/lcd_cap_pkg.sv
package lcd_cap_pkg;
  localparam int unsigned DEF_NCOL  = 240;
  localparam int unsigned DEF_BPP   = 6;
  localparam int unsigned DEF_LANES = 3;

  // Expand a code to all-ones or all-zeros from its MSB (8-color mode)
  function automatic logic [DEF_BPP-1:0] msb_fill(input logic [DEF_BPP-1:0] code);
    return {DEF_BPP{code[DEF_BPP-1]}};
  endfunction
endpackage

// File: rtl/lcd_cap_seq.sv
module lcd_cap_seq #(
  parameter int unsigned WORDS = 80,
  parameter int unsigned PW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic          start_l_in,
  input  logic          start_r_in,
  input  logic          strobe_rise,
  output logic          wr_en,
  output logic [PW-1:0] wr_ptr,
  output logic          wr_dir,
  output logic          start_l_out,
  output logic          start_r_out
);
  logic          busy;
  logic          dir_q;
  logic [PW-1:0] ptr;
  logic          start_act;
  logic          last;

  assign start_act = dir ? start_r_in : start_l_in;
  assign wr_dir    = busy ? dir_q : dir;
  assign wr_ptr    = busy ? ptr : '0;
  assign wr_en     = !strobe_rise && (busy || start_act);
  assign last      = (wr_ptr == PW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      dir_q       <= 1'b0;
      ptr         <= '0;
      start_l_out <= 1'b0;
      start_r_out <= 1'b0;
    end else begin
      start_l_out <= 1'b0;
      start_r_out <= 1'b0;
      if (strobe_rise) begin
        busy <= 1'b0;
        ptr  <= '0;
      end else if (wr_en) begin
        dir_q <= wr_dir;
        if (last) begin
          busy        <= 1'b0;
          ptr         <= '0;
          start_l_out <= wr_dir;
          start_r_out <= !wr_dir;
        end else begin
          busy <= 1'b1;
          ptr  <= wr_ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_cap_store.sv
module lcd_cap_store
  import lcd_cap_pkg::*;
#(
  parameter int unsigned NCOL  = 240,
  parameter int unsigned BPP   = 6,
  parameter int unsigned LANES = 3,
  parameter int unsigned PW    = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PW-1:0]         wr_ptr,
  input  logic                  wr_dir,
  input  logic [BPP*LANES-1:0]  word,
  input  logic                  inv,
  input  logic                  latch,
  input  logic                  mode8,
  output logic [NCOL*BPP-1:0]   row_codes
);
  logic [BPP*LANES-1:0] word_in;
  logic [BPP-1:0]       dreg [NCOL];
  logic [BPP-1:0]       lat  [NCOL];

  assign word_in = inv ? ~word : word;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int unsigned TR = c / LANES;
    localparam int unsigned JR = c % LANES;
    localparam int unsigned CL = NCOL - 1 - c;
    localparam int unsigned TL = CL / LANES;
    localparam int unsigned JL = CL % LANES;
    logic hit;

    assign hit = wr_en && (wr_dir ? (wr_ptr == PW'(TR)) : (wr_ptr == PW'(TL)));

    always_ff @(posedge clk) begin
      if (rst)
        dreg[c] <= '0;
      else if (hit)
        dreg[c] <= wr_dir ? word_in[JR*BPP +: BPP] : word_in[JL*BPP +: BPP];
    end

    always_ff @(posedge clk) begin
      if (rst)
        lat[c] <= '0;
      else if (latch)
        lat[c] <= mode8 ? {BPP{dreg[c][BPP-1]}} : dreg[c];
    end

    assign row_codes[c*BPP +: BPP] = lat[c];
  end
endmodule

// File: rtl/lcd_cap_pol.sv
module lcd_cap_pol (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic pol_in,
  input  logic com_sel,
  output logic strobe_rise,
  output logic pol_out,
  output logic com_out,
  output logic out_en,
  output logic row_valid
);
  logic strobe_q;
  logic pol_n;
  logic valid_n;

  assign strobe_rise = strobe && !strobe_q;
  assign pol_n       = strobe_rise ? pol_in : pol_out;
  assign valid_n     = row_valid || strobe_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      pol_out   <= 1'b0;
      com_out   <= 1'b0;
      out_en    <= 1'b0;
      row_valid <= 1'b0;
    end else begin
      strobe_q  <= strobe;
      pol_out   <= pol_n;
      com_out   <= com_sel && !pol_n;
      row_valid <= valid_n;
      out_en    <= valid_n && !strobe;
    end
  end
endmodule

// File: rtl/lcd_col_capture.sv
module lcd_col_capture
  import lcd_cap_pkg::*;
#(
  parameter int unsigned NCOL  = DEF_NCOL,
  parameter int unsigned BPP   = DEF_BPP,
  parameter int unsigned LANES = DEF_LANES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dir_right,
  input  logic                  start_l_in,
  input  logic                  start_r_in,
  output logic                  start_l_out,
  output logic                  start_r_out,
  input  logic [BPP*LANES-1:0]  pix_in,
  input  logic                  inv_en,
  input  logic                  strobe,
  input  logic                  pol_in,
  input  logic                  com_sel,
  input  logic                  mode8,
  output logic [NCOL*BPP-1:0]   row_codes,
  output logic                  pol_out,
  output logic                  com_out,
  output logic                  out_en,
  output logic                  row_valid
);
  localparam int unsigned WORDS = NCOL / LANES;
  localparam int unsigned PW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic          strobe_rise;
  logic          wr_en;
  logic          wr_dir;
  logic [PW-1:0] wr_ptr;

  lcd_cap_pol u_pol (
    .clk(clk), .rst(rst), .strobe(strobe), .pol_in(pol_in), .com_sel(com_sel),
    .strobe_rise(strobe_rise), .pol_out(pol_out), .com_out(com_out),
    .out_en(out_en), .row_valid(row_valid)
  );

  lcd_cap_seq #(.WORDS(WORDS), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .dir(dir_right), .start_l_in(start_l_in),
    .start_r_in(start_r_in), .strobe_rise(strobe_rise), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .wr_dir(wr_dir), .start_l_out(start_l_out),
    .start_r_out(start_r_out)
  );

  lcd_cap_store #(.NCOL(NCOL), .BPP(BPP), .LANES(LANES), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_dir(wr_dir),
    .word(pix_in), .inv(inv_en), .latch(strobe), .mode8(mode8),
    .row_codes(row_codes)
  );
endmodule

// File: rtl/lcd_col_capture_chk.sv
module lcd_col_capture_chk #(
  parameter int unsigned W = 1440
) (
  input logic         clk,
  input logic         rst,
  input logic         strobe,
  input logic         com_sel,
  input logic         start_l_out,
  input logic         start_r_out,
  input logic [W-1:0] row_codes,
  input logic         pol_out,
  input logic         com_out,
  input logic         out_en,
  input logic         row_valid
);
  assert_cascade_pulse_l_R4: assert property (@(posedge clk) disable iff (rst)
    start_l_out |=> !start_l_out);
  assert_cascade_pulse_r_R4: assert property (@(posedge clk) disable iff (rst)
    start_r_out |=> !start_r_out);
  assert_cascade_one_side_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_l_out, start_r_out}));
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(row_codes));
  assert_pol_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$rose(strobe) |=> $stable(pol_out));
  assert_com_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !com_sel |=> !com_out);
  assert_oe_off_R10: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !out_en);
  assert_oe_valid_R10: assert property (@(posedge clk) disable iff (rst)
    out_en |-> row_valid);
endmodule

bind lcd_col_capture lcd_col_capture_chk #(.W(NCOL*BPP)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .com_sel(com_sel),
  .start_l_out(start_l_out), .start_r_out(start_r_out), .row_codes(row_codes),
  .pol_out(pol_out), .com_out(com_out), .out_en(out_en), .row_valid(row_valid)
);

// File: tb/lcd_col_capture_tb.sv
module lcd_col_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 240;

  logic clk = 0;
  logic rst = 1;
  logic dir_right = 0, start_l_in = 0, start_r_in = 0;
  logic start_l_out, start_r_out;
  logic [17:0] pix_in = '0;
  logic inv_en = 0, strobe = 0, pol_in = 0, com_sel = 0, mode8 = 0;
  logic [NC*6-1:0] row_codes;
  logic pol_out, com_out, out_en, row_valid;

  int checks = 0, errors = 0;
  int exp_d [NC];
  int exp_l [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_col_capture u_dut (
    .clk(clk), .rst(rst), .dir_right(dir_right), .start_l_in(start_l_in),
    .start_r_in(start_r_in), .start_l_out(start_l_out), .start_r_out(start_r_out),
    .pix_in(pix_in), .inv_en(inv_en), .strobe(strobe), .pol_in(pol_in),
    .com_sel(com_sel), .mode8(mode8), .row_codes(row_codes), .pol_out(pol_out),
    .com_out(com_out), .out_en(out_en), .row_valid(row_valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int code_of(input int seed, input int k, input int j);
    return (k * 7 + j * 13 + seed) & 63;
  endfunction

  // Drive n words; start on word 0 if first, extra start on word ss
  task automatic send_words(input bit dr, input int seed, input bit inv, input int n,
                            input bit first, input int ss, input bit record, input string tag);
    int cas_bad = 0;
    dir_right = dr;
    inv_en = inv;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 3; j++) pix_in[j*6 +: 6] = 6'(code_of(seed, k, j));
      if ((k == 0 && first) || k == ss) begin
        if (dr) start_r_in = 1; else start_l_in = 1;
      end
      if (record)
        for (int j = 0; j < 3; j++) begin
          int col = dr ? (3*k + j) : (NC - 1 - (3*k + j));
          exp_d[col] = inv ? (~code_of(seed, k, j) & 63) : code_of(seed, k, j);
        end
      tick();
      start_l_in = 0;
      start_r_in = 0;
      if (n == 80 && first) begin
        if ((dr ? start_l_out : start_r_out) != (k == 79)) cas_bad++;
        if ((dr ? start_r_out : start_l_out) != 1'b0) cas_bad++;
      end
    end
    inv_en = 0;
    if (n == 80 && first) begin
      chk(cas_bad == 0, {tag, " R4 cascade pulse timing"}, cas_bad, 0);
      tick();
      chk(!start_l_out && !start_r_out, {tag, " R4 pulse one cycle"},
          int'(start_l_out) + int'(start_r_out), 0);
    end
  endtask

  task automatic do_strobe(input bit pol, input string tag);
    strobe = 1;
    pol_in = pol;
    for (int c = 0; c < NC; c++)
      exp_l[c] = mode8 ? ((exp_d[c] & 32) != 0 ? 63 : 0) : exp_d[c];
    tick();
    chk(out_en == 0, {tag, " R10 enable off at strobe"}, out_en, 0);
    chk(row_valid == 1, {tag, " R10 valid after strobe"}, row_valid, 1);
    chk(pol_out == pol, {tag, " R8 polarity captured"}, pol_out, pol);
    strobe = 0;
    pol_in = ~pol;
    tick();
    chk(out_en == 1, {tag, " R10 enable on after fall"}, out_en, 1);
  endtask

  task automatic check_latch(input string tag);
    int bad = 0, fc = -1, fa = 0, fe = 0;
    for (int c = 0; c < NC; c++)
      if (int'(row_codes[c*6 +: 6]) != exp_l[c]) begin
        if (fc < 0) begin fc = c; fa = int'(row_codes[c*6 +: 6]); fe = exp_l[c]; end
        bad++;
      end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: column %0d actual %0d expected %0d (%0d bad)", tag, fc, fa, fe, bad);
    end
  endtask

  task automatic t_reset();
    chk(row_codes == '0, "R1 codes zero", 0, 0);
    chk({pol_out, com_out, out_en, row_valid} == 4'b0, "R1 flags zero",
        int'({pol_out, com_out, out_en, row_valid}), 0);
    chk(!start_l_out && !start_r_out, "R1 start outputs zero",
        int'({start_l_out, start_r_out}), 0);
  endtask

  task automatic t_right();
    send_words(1, 5, 0, 80, 1, -1, 1, "right");
    chk(row_codes == '0, "R5 no latch before strobe", 0, 0);
    chk(out_en == 0, "R10 enable needs first strobe", out_en, 0);
    do_strobe(1, "right");
    check_latch("R2 rightward mapping");
  endtask

  task automatic t_left();
    send_words(0, 11, 0, 80, 1, -1, 1, "left");
    check_latch("R5 latch unchanged by capture");
    do_strobe(0, "left");
    check_latch("R3 leftward mapping");
  endtask

  task automatic t_invert();
    send_words(1, 20, 1, 80, 1, -1, 1, "invert");
    do_strobe(1, "invert");
    check_latch("R7 inverted capture");
  endtask

  task automatic t_abort();
    send_words(1, 30, 0, 10, 1, -1, 1, "abort");
    do_strobe(0, "abort");
    check_latch("R6 partial row latched");
    send_words(1, 77, 0, 20, 0, -1, 0, "abort");
    do_strobe(0, "abort2");
    check_latch("R6 words after strobe ignored");
  endtask

  task automatic t_restart();
    send_words(0, 40, 0, 80, 1, 6, 1, "restart R12");
    do_strobe(1, "restart");
    check_latch("R12 mid-row start ignored");
  endtask

  task automatic t_pol();
    bit held = pol_out;
    for (int k = 0; k < 5; k++) begin
      pol_in = k[0];
      tick();
    end
    chk(pol_out == held, "R8 polarity holds without strobe", pol_out, held);
    do_strobe(0, "pol");
    chk(pol_out == 0, "R8 polarity held after strobe", pol_out, 0);
  endtask

  task automatic t_com();
    com_sel = 1;
    tick();
    chk(com_out == !pol_out, "R9 com follows inverted polarity", com_out, !pol_out);
    do_strobe(1, "com");
    chk(com_out == 0, "R9 com for positive polarity", com_out, 0);
    do_strobe(0, "com2");
    chk(com_out == 1, "R9 com for negative polarity", com_out, 1);
    com_sel = 0;
    tick();
    chk(com_out == 0, "R9 com gated low", com_out, 0);
  endtask

  task automatic t_mode8();
    mode8 = 1;
    do_strobe(0, "mode8");
    check_latch("R11 msb expansion");
    mode8 = 0;
    do_strobe(0, "mode8 off");
    check_latch("R11 normal after mode8");
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin exp_d[c] = 0; exp_l[c] = 0; end
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_right();
    t_left();
    t_invert();
    t_abort();
    t_restart();
    t_pol();
    t_com();
    t_mode8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule